// File: doc/BRIEF.md
# Programmable Interval Timer Bank

This block provides a set of independent interval timers for a supervisory power-sequencing controller. Each channel has its own start level, its own 7-bit interval code and its own timeout flag. The control logic raises a channel's start input and later reads the timeout flag to learn that the chosen delay has passed. It lowers start to clear the channel.

The timers count a free-running clock of about 250 kHz. The interval code is split into a 4-bit exponent and a 3-bit mantissa. The delay in clock cycles is the mantissa with an implied leading one, shifted left by the exponent. This gives 128 settings that run from 8 cycles (32 us) to 491,520 cycles (about 1.97 s). Adjacent settings are about 7 to 13 percent apart. A channel captures its terminal count on the cycle it starts, so the sequencer may rewrite a code while that channel is still running.

Top module: `pitb_timer_bank`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, every timeout output is low.
- R2: A channel's interval code has the exponent E in bits [6:3] and the mantissa M in bits [2:0]. Its timeout rises on exactly the ((8+M) << E)-th rising clock edge at which start is sampled high, counting from the first such edge.
- R3: The timeout stays low on every edge before the terminal edge. The shortest code (0) raises it on the 8th edge.
- R4: Once high, a timeout stays high for as long as its start input stays high.
- R5: On the first edge where start is sampled low, the channel's timeout goes low and its count returns to zero.
- R6: When start is raised again after being low for at least one edge, timing restarts from zero, whatever the earlier partial count was.
- R7: The interval code is captured on the first edge of a run. Later changes to it do not move that run's timeout edge.
- R8: Each channel runs independently. Channels started together with different codes each time out at their own edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Timer clock, about 250 kHz |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | NUM_TMR | Per-channel start level; high runs the channel, low clears it |
| sel_i | input | NUM_TMR*7 | Interval codes; channel k uses bits [7k+6:7k] |
| timeout_o | output | NUM_TMR | Per-channel timeout flag |

## Verification
The assertions assume that start and the interval codes are synchronous to the timer clock and hold known values from the first edge after reset. The bench meets this by driving every input on the falling edge only, and it never leaves an input undefined after reset. The checks on a held timeout and on clearing assume that start is a level and not a one-cycle pulse. The stimulus therefore holds start across whole runs. Where a restart is tested, it lowers start for a full cycle first.

// File: rtl/pitb_pkg.sv
package pitb_pkg;

   typedef enum logic [1:0] {
      CH_IDLE = 2'b00,
      CH_RUN  = 2'b01,
      CH_DONE = 2'b10
   } pitb_state_e;

endpackage

// File: rtl/pitb_interval_decode.sv
module pitb_interval_decode #(
   parameter int MAN_W = 3,
   parameter int EXP_W = 4,
   localparam int SEL_W = MAN_W + EXP_W,
   localparam int CNT_W = MAN_W + (1 << EXP_W)
) (
   input  logic [SEL_W-1:0] sel_i,
   output logic [CNT_W-1:0] term_o
);

   generate
      if (MAN_W < 1 || MAN_W > 8) begin : g_bad_man
         $error("pitb_interval_decode: MAN_W must be 1..8");
      end
      if (EXP_W < 1 || EXP_W > 5) begin : g_bad_exp
         $error("pitb_interval_decode: EXP_W must be 1..5");
      end
   endgenerate

   logic [CNT_W-1:0]  base;
   logic [EXP_W-1:0]  shamt;

   // implied leading one keeps adjacent codes a bounded ratio apart
   assign base   = {{(CNT_W-MAN_W-1){1'b0}}, 1'b1, sel_i[MAN_W-1:0]};
   assign shamt  = sel_i[SEL_W-1:MAN_W];
   assign term_o = base << shamt;

endmodule

// File: rtl/pitb_channel.sv
module pitb_channel
   import pitb_pkg::*;
#(
   parameter int MAN_W = 3,
   parameter int EXP_W = 4,
   localparam int SEL_W = MAN_W + EXP_W,
   localparam int CNT_W = MAN_W + (1 << EXP_W)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             timeout_o
);

   logic [CNT_W-1:0] term_d;
   logic [CNT_W-1:0] term_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nxt;
   pitb_state_e      state_q;

   pitb_interval_decode #(
      .MAN_W (MAN_W),
      .EXP_W (EXP_W)
   ) u_decode (
      .sel_i  (sel_i),
      .term_o (term_d)
   );

   assign cnt_nxt = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q <= CH_IDLE;
         cnt_q   <= '0;
         term_q  <= '0;
      end else if (!start_i) begin
         state_q <= CH_IDLE;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            CH_IDLE: begin
               state_q <= CH_RUN;
               term_q  <= term_d;
               cnt_q   <= {{(CNT_W-1){1'b0}}, 1'b1};
            end
            CH_RUN: begin
               cnt_q <= cnt_nxt;
               if (cnt_nxt == term_q) state_q <= CH_DONE;
            end
            CH_DONE: state_q <= CH_DONE;
            default: state_q <= CH_IDLE;
         endcase
      end
   end

   assign timeout_o = (state_q == CH_DONE);

   AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == CH_RUN) |-> (cnt_q < term_q)); // R3
   AST_RISE_AT_TERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(timeout_o) |-> (cnt_q == term_q)); // R2
   AST_HOLD_WHILE_STARTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && timeout_o) |=> timeout_o); // R4
   AST_CLEAR_ON_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !start_i |=> (!timeout_o && cnt_q == '0)); // R5
   AST_RESTART_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && state_q == CH_IDLE) |=> (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1})); // R6
   AST_TERM_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && state_q != CH_IDLE) |=> $stable(term_q)); // R7

endmodule

// File: rtl/pitb_timer_bank.sv
module pitb_timer_bank #(
   parameter int NUM_TMR = 4,
   parameter int MAN_W   = 3,
   parameter int EXP_W   = 4
) (
   input  logic                             clk_i,
   input  logic                             rst_ni,
   input  logic [NUM_TMR-1:0]               start_i,
   input  logic [NUM_TMR*(MAN_W+EXP_W)-1:0] sel_i,
   output logic [NUM_TMR-1:0]               timeout_o
);

   localparam int SEL_W = MAN_W + EXP_W;

   generate
      if (NUM_TMR < 1 || NUM_TMR > 32) begin : g_bad_num
         $error("pitb_timer_bank: NUM_TMR must be 1..32");
      end
      for (genvar k = 0; k < NUM_TMR; k++) begin : g_ch
         pitb_channel #(
            .MAN_W (MAN_W),
            .EXP_W (EXP_W)
         ) u_ch (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .start_i   (start_i[k]),
            .sel_i     (sel_i[k*SEL_W +: SEL_W]),
            .timeout_o (timeout_o[k])
         );
      end
   endgenerate

   AST_RESET_QUIET: assert property (@(posedge clk_i)
      !rst_ni |=> (timeout_o == '0)); // R1

endmodule

// File: tb/pitb_timer_bank_tb.sv
module pitb_timer_bank_tb;

   localparam int N = 4;
   localparam int MW = 3;
   localparam int EW = 4;
   localparam int SW = MW + EW;

   logic            clk = 1'b0;
   logic            rst_n;
   logic [N-1:0]    start;
   logic [N*SW-1:0] sel;
   logic [N-1:0]    timeout;

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   pitb_timer_bank #(.NUM_TMR(N), .MAN_W(MW), .EXP_W(EW)) u_dut (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .start_i   (start),
      .sel_i     (sel),
      .timeout_o (timeout)
   );

   // behavioural reference model
   int  m_cnt  [N];
   int  m_term [N];
   bit  m_run  [N];
   bit  m_done [N];

   function automatic int ref_term(input logic [SW-1:0] code);
      int e = int'(code[SW-1:MW]);
      int m = int'(code[MW-1:0]);
      return ((1 << MW) + m) * (1 << e);
   endfunction

   always @(posedge clk) begin
      for (int c = 0; c < N; c++) begin
         if (!rst_n || !start[c]) begin
            m_run[c] = 0; m_done[c] = 0; m_cnt[c] = 0;
         end else if (!m_run[c]) begin
            m_run[c] = 1; m_cnt[c] = 1;
            m_term[c] = ref_term(sel[c*SW +: SW]);
         end else if (!m_done[c]) begin
            m_cnt[c] = m_cnt[c] + 1;
            if (m_cnt[c] == m_term[c]) m_done[c] = 1;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n === 1'b1 && !finished) begin
         for (int c = 0; c < N; c++) begin
            checks++;
            if (timeout[c] !== m_done[c]) begin
               errors++;
               $display("FAIL R2/R8 model ch%0d: actual=%b expected=%b", c, timeout[c], m_done[c]);
            end
         end
      end
   end

   task automatic check(input logic [N-1:0] act, input logic [N-1:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_code(input int c, input int e, input int m);
      sel[c*SW +: SW] = SW'((e << MW) | m);
   endtask

   task automatic finish_run();
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; start = '0; sel = '0;
      step(3);
      check(timeout, 4'b0000, "R1 in reset");
      rst_n = 1'b1;
      step(1);
      check(timeout, 4'b0000, "R1 after reset");

      // R3 shortest code: 8 edges
      set_code(0, 0, 0); start[0] = 1'b1;
      step(7); check(timeout, 4'b0000, "R3 before terminal");
      step(1); check(timeout, 4'b0001, "R3 at terminal");
      // R4 held
      step(50); check(timeout, 4'b0001, "R4 held while started");
      // R5 clear
      start[0] = 1'b0;
      step(1); check(timeout, 4'b0000, "R5 cleared");

      // R2 E=3 M=5 -> 104
      set_code(1, 3, 5); start[1] = 1'b1;
      step(103); check(timeout, 4'b0000, "R2 e3m5 before");
      step(1); check(timeout, 4'b0010, "R2 e3m5 at 104");
      start[1] = 1'b0; step(1);

      // R6 restart: E=2 M=2 -> 40
      set_code(2, 2, 2); start[2] = 1'b1;
      step(30); start[2] = 1'b0;
      step(1); check(timeout, 4'b0000, "R6 partial cleared");
      start[2] = 1'b1;
      step(39); check(timeout, 4'b0000, "R6 restart before");
      step(1); check(timeout, 4'b0100, "R6 restart at 40");
      start[2] = 1'b0; step(1);

      // R7 code change mid-run ignored: E=4 M=1 -> 144
      set_code(3, 4, 1); start[3] = 1'b1;
      step(5); set_code(3, 0, 0);
      step(138); check(timeout, 4'b0000, "R7 new code ignored");
      step(1); check(timeout, 4'b1000, "R7 original terminal");
      start[3] = 1'b0; step(1);

      // R8 simultaneous: 16, 24, 15, 32
      set_code(0, 1, 0); set_code(1, 1, 4); set_code(2, 0, 7); set_code(3, 2, 0);
      start = 4'b1111;
      step(15); check(timeout, 4'b0100, "R8 ch2 at 15");
      step(1);  check(timeout, 4'b0101, "R8 ch0 at 16");
      step(8);  check(timeout, 4'b0111, "R8 ch1 at 24");
      step(8);  check(timeout, 4'b1111, "R8 ch3 at 32");
      start = 4'b0000; step(1);
      check(timeout, 4'b0000, "R5 all cleared");

      // R2 long codes: E=12 M=7 -> 61440 on ch0, E=10 M=0 -> 8192 on ch3
      set_code(0, 12, 7); set_code(3, 10, 0);
      start = 4'b1001;
      step(8191); check(timeout, 4'b0000, "R2 e10 before");
      step(1);    check(timeout, 4'b1000, "R2 e10 at 8192");
      step(61440 - 8192 - 1); check(timeout, 4'b1000, "R2 e12m7 before");
      step(1);    check(timeout, 4'b1001, "R2 e12m7 at 61440");
      start = '0; step(2);

      finish_run();
   end

endmodule